// File: doc/BRIEF.md
# Interline Chroma Averaging Filter

This block filters a stream of 8-bit colour-difference samples (Cb/Cr) by blending each sample with the sample at the same position on the line before. A one-line store holds the previous line. The position within a line is counted from a start-of-line strobe. The count advances only on cycles that carry a valid sample.

A two-bit mode input selects one of three behaviours. Adaptive mode blends only when the two samples agree closely. Forced mode always blends. Bypass mode never blends. A two-bit standard input tells the block which broadcast family is being decoded. The SECAM family never blends.

Blending is also suppressed until one full line has been stored since reset or since the last change of standard. The filtered sample and the delayed strobes appear one clock after the input, and they stay aligned with each other.

Top module: `chroma_line_avg`

## Requirements
- R1: With `mode` = 2'b00 (adaptive), a sample is replaced by the blend when |cur − prev| ≤ `thresh`, and it passes unchanged when the difference is larger.
- R2: With `mode` = 2'b01 (forced), every sample is replaced by the blend with the co-located sample of the preceding line.
- R3: With `mode` = 2'b10 (off) or 2'b11 (reserved), every sample passes unchanged.
- R4: `std_sel` = 2'b00 (PAL family) or 2'b01 (NTSC family) allows blending. `std_sel` = 2'b10 (SECAM) or 2'b11 (treated as SECAM) passes every sample unchanged in any mode.
- R5: The blend is (cur + prev + 1) >> 1, computed without overflow, so two samples of 255 give 255.
- R6: On the first line after reset, and on the first line after `std_sel` changes, samples pass unchanged.
- R7: `out_data`, `out_valid` and `out_sol` follow `in_data`, `in_valid` and `in_sol` with a latency of exactly one clock.
- R8: While reset is asserted, `out_valid` and `out_sol` are 0 and `out_data` is 0.
- R9: The position in a line counts valid samples from the one that carries `in_sol`. Idle cycles (`in_valid` = 0) do not shift the alignment with the previous line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample qualifier |
| in_sol | input | 1 | First valid sample of a line |
| in_data | input | 8 | Input chroma sample |
| mode | input | 2 | 00 adaptive, 01 forced, 10 off, 11 reserved (off) |
| std_sel | input | 2 | 00 PAL family, 01 NTSC family, 10/11 SECAM |
| thresh | input | 8 | Adaptive correlation threshold |
| out_valid | output | 1 | Output sample qualifier |
| out_sol | output | 1 | Delayed start-of-line strobe |
| out_data | output | 8 | Filtered chroma sample |

## Verification
The main function is driven with ramps whose line-to-line difference is small, large, exactly equal to the threshold and one above it. These patterns separate the adaptive decision from forced blending and show on which side of the threshold the equal case falls. Lines of 255 are blended with 255 and with 0 to expose rounding and overflow. A standard change, a reset and the off and reserved codes must each leave the samples untouched. A line with idle gaps shows whether the position count drifts.

// File: rtl/cavg_pkg.sv
package cavg_pkg;
  typedef enum logic [1:0] {
    MODE_ADAPT  = 2'b00,
    MODE_FORCE  = 2'b01,
    MODE_OFF    = 2'b10,
    MODE_RSVD   = 2'b11
  } avg_mode_e;

  typedef enum logic [1:0] {
    STD_PAL   = 2'b00,
    STD_NTSC  = 2'b01,
    STD_SECAM = 2'b10,
    STD_ALT   = 2'b11
  } std_e;
endpackage

// File: rtl/cavg_line_mem.sv
module cavg_line_mem #(
  parameter int DEPTH = 720,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  // read-before-write: rdata shows the previous line at this position
  assign rdata = store[addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[addr] <= wdata;
    end
  end
endmodule

// File: rtl/cavg_decide.sv
module cavg_decide
  import cavg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic         prev_ok,
  input  logic [1:0]   mode,
  input  logic [1:0]   std_sel,
  input  logic [W-1:0] thresh,
  output logic [W-1:0] result,
  output logic         blend
);
  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         std_allows;

  always_comb begin
    sum        = {1'b0, cur} + {1'b0, prev} + {{W{1'b0}}, 1'b1};
    diff       = (cur >= prev) ? (cur - prev) : (prev - cur);
    std_allows = (std_sel == STD_PAL) || (std_sel == STD_NTSC);
    blend      = 1'b0;
    if (prev_ok && std_allows) begin
      unique case (avg_mode_e'(mode))
        MODE_ADAPT: blend = (diff <= thresh);
        MODE_FORCE: blend = 1'b1;
        default:    blend = 1'b0;
      endcase
    end
    result = blend ? sum[W:1] : cur;
  end
endmodule

// File: rtl/chroma_line_avg.sv
module chroma_line_avg
  import cavg_pkg::*;
#(
  parameter int LINE_LEN = 720,
  parameter int W        = 8,
  localparam int AW      = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1,
  localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sol,
  input  logic [W-1:0] in_data,
  input  logic [1:0]   mode,
  input  logic [1:0]   std_sel,
  input  logic [W-1:0] thresh,
  output logic         out_valid,
  output logic         out_sol,
  output logic [W-1:0] out_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  // line position and previous-line bookkeeping
  logic [AW-1:0] idx_q, idx_n, cur_idx;
  logic [1:0]    std_q;
  logic          seen_q, seen_n, pok_q, pok_n;
  logic          std_chg, use_prev, pos_en;
  logic [W-1:0]  prev_smp, res;
  logic          blend;
  logic          ov_n, os_n;
  logic [W-1:0]  od_n;

  always_comb begin
    std_chg  = (std_sel != std_q);
    cur_idx  = in_sol ? '0 : idx_q;
    use_prev = !std_chg && (in_sol ? seen_q : pok_q);
    pos_en   = in_valid;
    idx_n    = (cur_idx == LAST) ? cur_idx : cur_idx + 1'b1;
    seen_n   = std_chg ? in_valid : (seen_q | in_valid);
    pok_n    = pok_q;
    if (std_chg)               pok_n = 1'b0;
    else if (in_valid && in_sol) pok_n = seen_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      idx_q  <= '0;
      std_q  <= STD_PAL;
      seen_q <= 1'b0;
      pok_q  <= 1'b0;
    end else begin
      std_q  <= std_sel;
      seen_q <= seen_n;
      pok_q  <= pok_n;
      if (pos_en) idx_q <= idx_n;
    end
  end

  cavg_line_mem #(.DEPTH(LINE_LEN), .W(W)) i_mem (
    .clk   (clk),
    .wr_en (in_valid),
    .addr  (cur_idx),
    .wdata (in_data),
    .rdata (prev_smp)
  );

  cavg_decide #(.W(W)) i_dec (
    .cur     (in_data),
    .prev    (prev_smp),
    .prev_ok (use_prev && in_valid),
    .mode    (mode),
    .std_sel (std_sel),
    .thresh  (thresh),
    .result  (res),
    .blend   (blend)
  );

  // output stage
  always_comb begin
    ov_n = in_valid;
    os_n = in_valid && in_sol;
    od_n = in_valid ? res : out_data;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= ov_n;
      out_sol   <= os_n;
      out_data  <= od_n;
    end
  end

  // checks
  logic [W-1:0] chk_diff;
  assign chk_diff = (in_data >= prev_smp) ? (in_data - prev_smp) : (prev_smp - in_data);

  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R4
  secam_pass_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && std_sel[1]) |=> (out_data == $past(in_data)));

  // R3
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && mode[1]) |=> (out_data == $past(in_data)));

  // R1
  uncorr_pass_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && mode == MODE_ADAPT && chk_diff > thresh) |=> (out_data == $past(in_data)));

  // R5
  avg_range_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && blend) |->
      ((res >= ((in_data < prev_smp) ? in_data : prev_smp)) &&
       (res <= ((in_data < prev_smp) ? prev_smp : in_data))));
endmodule

// File: tb/test_chroma_line_avg.sv
module test_chroma_line_avg;
  localparam int CLK_PERIOD = 10;
  localparam int LEN        = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sol;
  logic [7:0] in_data, thresh;
  logic [1:0] mode, std_sel;
  logic       out_valid, out_sol;
  logic [7:0] out_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chroma_line_avg #(.LINE_LEN(LEN), .W(8)) i_chroma_line_avg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_data(in_data), .mode(mode), .std_sel(std_sel), .thresh(thresh),
    .out_valid(out_valid), .out_sol(out_sol), .out_data(out_data)
  );

  typedef struct packed {
    logic [1:0] md;
    logic [1:0] sd;
    logic [7:0] thr;
    logic [7:0] base;
    logic [7:0] step;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b00, 8'd4,   8'd100, 8'd3},
    '{2'b00, 2'b00, 8'd4,   8'd102, 8'd3},
    '{2'b00, 2'b00, 8'd4,   8'd90,  8'd5},
    '{2'b01, 2'b00, 8'd0,   8'd200, 8'd1},
    '{2'b01, 2'b01, 8'd0,   8'd50,  8'd7},
    '{2'b01, 2'b01, 8'd0,   8'd255, 8'd0},
    '{2'b01, 2'b01, 8'd0,   8'd255, 8'd0},
    '{2'b01, 2'b01, 8'd0,   8'd0,   8'd0},
    '{2'b10, 2'b01, 8'd255, 8'd10,  8'd2},
    '{2'b11, 2'b01, 8'd255, 8'd30,  8'd1},
    '{2'b01, 2'b10, 8'd255, 8'd77,  8'd1},
    '{2'b00, 2'b10, 8'd255, 8'd1,   8'd9},
    '{2'b00, 2'b00, 8'd8,   8'd40,  8'd0},
    '{2'b00, 2'b00, 8'd8,   8'd48,  8'd0},
    '{2'b00, 2'b00, 8'd8,   8'd57,  8'd0},
    '{2'b01, 2'b11, 8'd0,   8'd5,   8'd3}
  };

  // bench reference state
  logic [7:0] ref_prev [LEN];
  logic       have_line;
  logic [1:0] last_std;

  function automatic logic [7:0] expect_smp(input logic [7:0] c, input logic [7:0] p,
      input logic ok, input logic [1:0] md, input logic [1:0] sd,
      input logic [7:0] thr, output string tag);
    int d;
    logic [7:0] av;
    d  = (c >= p) ? int'(c) - int'(p) : int'(p) - int'(c);
    av = 8'((int'(c) + int'(p) + 1) / 2);
    if (sd[1])            begin tag = "R4"; return c; end
    if (!ok)              begin tag = "R6"; return c; end
    if (md[1])            begin tag = "R3"; return c; end
    if (md == 2'b01)      begin tag = (c == 8'd255 || c == 8'd0) ? "R5" : "R2"; return av; end
    tag = "R1";
    return (d <= int'(thr)) ? av : c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  // drive one sample at a falling edge, check it at the next falling edge
  task automatic send(input logic sol, input logic [7:0] d, input logic [7:0] exp_d,
      input string tag);
    in_valid = 1'b1; in_sol = sol; in_data = d;
    @(negedge clk);
    check("R7", {31'd0, out_valid}, 32'd1);
    check("R7", {31'd0, out_sol}, {31'd0, sol});
    check(tag, {24'd0, out_data}, {24'd0, exp_d});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b0; in_sol = 1'b0; in_data = 8'hA5;
      @(negedge clk);
      check("R9", {31'd0, out_valid}, 32'd0);
    end
  endtask

  task automatic run_line(input logic [1:0] md, input logic [1:0] sd, input logic [7:0] thr,
      input logic [7:0] base, input logic [7:0] step, input bit gaps);
    logic ok;
    logic [7:0] c, e;
    string tag;
    mode = md; std_sel = sd; thresh = thr;
    ok = have_line && (sd == last_std);
    for (int i = 0; i < LEN; i++) begin
      c = 8'(int'(base) + i * int'(step));
      e = expect_smp(c, ref_prev[i], ok, md, sd, thr, tag);
      if (gaps) tag = "R9";
      send(i == 0, c, e, tag);
      ref_prev[i] = c;
      if (gaps && (i % 3 == 1)) idle(2);
    end
    have_line = 1'b1;
    last_std  = sd;
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_sol = 1'b0; in_data = '0;
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    check("R8", {31'd0, out_valid}, 32'd0);
    check("R8", {31'd0, out_sol}, 32'd0);
    check("R8", {24'd0, out_data}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    have_line = 1'b0;
    last_std  = 2'b00;
  endtask

  initial begin
    mode = 2'b00; std_sel = 2'b00; thresh = 8'd0;
    @(negedge clk);
    do_reset();

    for (int v = 0; v < NV; v++) begin
      run_line(VECS[v].md, VECS[v].sd, VECS[v].thr, VECS[v].base, VECS[v].step, 1'b0);
    end

    // R9: forced blending across lines with idle gaps
    run_line(2'b01, 2'b00, 8'd0, 8'd10, 8'd4, 1'b0);
    run_line(2'b01, 2'b00, 8'd0, 8'd20, 8'd6, 1'b1);
    run_line(2'b01, 2'b00, 8'd0, 8'd33, 8'd2, 1'b1);
    idle(2);

    // R6: a reset in mid-stream drops the stored line
    run_line(2'b01, 2'b00, 8'd0, 8'd60, 8'd1, 1'b0);
    do_reset();
    run_line(2'b01, 2'b00, 8'd0, 8'd160, 8'd2, 1'b0);
    run_line(2'b01, 2'b00, 8'd0, 8'd20, 8'd2, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule